// File: doc/BRIEF.md
# Single-Bus Register-to-Register Operation Sequencer

This block is a small datapath where every move between storage elements crosses one shared internal bus. It has a general register file, an operand latch that holds the left operand, a shifter on the bus path into the arithmetic unit, an add/subtract unit alongside bitwise logic units, a result selector, and a result latch. Only one source may drive the bus in a clock, so each register-to-register operation takes three sequenced transfers.

A client presents an operation request. The request names the destination register, the left and right source registers, the function code and a shift setting for the right operand. The block accepts the request only while idle and raises `busy`. It then works through three steps, one per clock. First, the left source goes over the bus into the operand latch. Second, the right source goes over the bus and through the shifter, and the selected function result is captured in the result latch. Third, the result latch drives the bus and the destination register is written. In the next cycle `done` pulses and `res_data` shows the value that was written.

Top module: `busdp_seq`

## Requirements
- R1: While `rst` is high and after it falls, `busy` and `done` are low and `res_data` is zero. Register k starts at (k+1) * 0x9E3779B9, keeping the low 32 bits.
- R2: A request with `req_valid` high while `busy` is low is accepted on that edge. `busy` is high in the three cycles that follow, and the write happens on the third edge after acceptance.
- R3: `done` is high for exactly the one cycle after the destination write. In that cycle `busy` is low and `res_data` holds the written value. `res_data` does not change in any cycle where `done` is low.
- R4: A request presented while `busy` is high is ignored. It writes no register and it neither lengthens nor restarts the operation in progress.
- R5: Function code 0 gives left + shifted right, and code 1 gives left − shifted right. Both wrap modulo 2^32.
- R6: Function code 2 gives AND, code 3 gives OR and code 4 gives XOR of left and shifted right. Codes 5 to 7 give the shifted right operand alone.
- R7: The shift applies only to the right operand. `req_shl`=1 selects a logical left shift and 0 a logical right shift, by `req_shamt` (0 to 31) bits with zero fill.
- R8: The destination may equal either source, or both. The result is computed from the source values as they were before the write.
- R9: The written result stays in the destination register and is seen by later operations that read that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request strobe |
| req_func | input | 3 | Function code |
| req_dst | input | 4 | Destination register index |
| req_srca | input | 4 | Left source register index |
| req_srcb | input | 4 | Right source register index |
| req_shl | input | 1 | Shift direction for right operand (1 = left) |
| req_shamt | input | 5 | Shift distance in bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 32 | Value written by the last completed operation |

## Verification
The assertions expect `req_valid` to be a clean level sampled at the rising edge. They also expect reset to be held for at least one edge before any request, so the count of consecutive busy cycles starts at zero. The bench changes every input on the falling edge. It keeps requests one cycle wide when the block is idle. Its only long requests are the ones it presents on purpose while `busy` is high, and it clears them before the block goes idle again, so the block accepts nothing it did not mean to send.

// File: rtl/busdp_pkg.sv
package busdp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOADY = 2'd1,
    ST_CALCZ = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_PASS = 3'd5
  } alu_fn_t;
endpackage

// File: rtl/busdp_regfile.sv
module busdp_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG = 16,
  parameter logic [DATA_W-1:0] RST_MULT = 32'h9E3779B9,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= RST_MULT * DATA_W'(i + 1);
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/busdp_alu.sv
module busdp_alu #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] y_val,
  input  logic [DATA_W-1:0] bus_val,
  input  logic              shl,
  input  logic [SH_W-1:0]   shamt,
  input  logic [2:0]        func,
  output logic [DATA_W-1:0] result
);
  import busdp_pkg::*;

  logic [DATA_W-1:0] rhs;
  logic [DATA_W-1:0] addsub;
  logic              sub_line;

  // shifter on the bus path into the ALU
  assign rhs = shl ? (bus_val << shamt) : (bus_val >> shamt);

  // one control line selects add or subtract
  assign sub_line = (func == FN_SUB);
  assign addsub   = y_val + (rhs ^ {DATA_W{sub_line}}) + DATA_W'(sub_line);

  always_comb begin
    case (func)
      FN_ADD, FN_SUB: result = addsub;
      FN_AND:         result = y_val & rhs;
      FN_OR:          result = y_val | rhs;
      FN_XOR:         result = y_val ^ rhs;
      default:        result = rhs;
    endcase
  end
endmodule

// File: rtl/busdp_ctrl.sv
module busdp_ctrl #(
  parameter int NREG = 16,
  parameter int SH_W = 5,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_func,
  input  logic [AW-1:0]   req_dst,
  input  logic [AW-1:0]   req_srca,
  input  logic [AW-1:0]   req_srcb,
  input  logic            req_shl,
  input  logic [SH_W-1:0] req_shamt,
  output logic            sel_z,
  output logic [AW-1:0]   rd_addr,
  output logic            y_load,
  output logic            z_load,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [2:0]      func,
  output logic            shl,
  output logic [SH_W-1:0] shamt,
  output logic            busy,
  output logic            done
);
  import busdp_pkg::*;

  seq_state_t          state;
  logic [AW-1:0]       op_srca, op_srcb;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      op_srca <= '0;
      op_srcb <= '0;
      wr_addr <= '0;
      func    <= '0;
      shl     <= 1'b0;
      shamt   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          state   <= ST_LOADY;
          busy    <= 1'b1;
          op_srca <= req_srca;
          op_srcb <= req_srcb;
          wr_addr <= req_dst;
          func    <= req_func;
          shl     <= req_shl;
          shamt   <= req_shamt;
        end
        ST_LOADY: state <= ST_CALCZ;
        ST_CALCZ: state <= ST_WRITE;
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
      endcase
    end
  end

  assign sel_z   = (state == ST_WRITE);
  assign rd_addr = (state == ST_CALCZ) ? op_srcb : op_srca;
  assign y_load  = (state == ST_LOADY);
  assign z_load  = (state == ST_CALCZ);
  assign wr_en   = (state == ST_WRITE);
endmodule

// File: rtl/busdp_seq.sv
module busdp_seq #(
  parameter int DATA_W = 32,
  parameter int NREG = 16,
  parameter logic [DATA_W-1:0] RST_MULT = 32'h9E3779B9,
  localparam int AW = $clog2(NREG),
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_func,
  input  logic [AW-1:0]     req_dst,
  input  logic [AW-1:0]     req_srca,
  input  logic [AW-1:0]     req_srcb,
  input  logic              req_shl,
  input  logic [SH_W-1:0]   req_shamt,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] res_data
);
  logic              sel_z, y_load, z_load, wr_en, shl;
  logic [AW-1:0]     rd_addr, wr_addr;
  logic [2:0]        func;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] rf_rd, bus, y_q, z_q, alu_out;

  busdp_ctrl #(.NREG(NREG), .SH_W(SH_W)) ctrl_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_func(req_func),
    .req_dst(req_dst), .req_srca(req_srca), .req_srcb(req_srcb),
    .req_shl(req_shl), .req_shamt(req_shamt), .sel_z(sel_z),
    .rd_addr(rd_addr), .y_load(y_load), .z_load(z_load), .wr_en(wr_en),
    .wr_addr(wr_addr), .func(func), .shl(shl), .shamt(shamt),
    .busy(busy), .done(done)
  );

  busdp_regfile #(.DATA_W(DATA_W), .NREG(NREG), .RST_MULT(RST_MULT)) rf_i (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rf_rd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(bus)
  );

  // single shared bus: one driver per clock
  assign bus = sel_z ? z_q : rf_rd;

  busdp_alu #(.DATA_W(DATA_W)) alu_i (
    .y_val(y_q), .bus_val(bus), .shl(shl), .shamt(shamt),
    .func(func), .result(alu_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q      <= '0;
      z_q      <= '0;
      res_data <= '0;
    end else begin
      if (y_load) y_q <= bus;
      if (z_load) z_q <= alu_out;
      if (wr_en)  res_data <= bus;
    end
  end
endmodule

// File: rtl/busdp_seq_chk.sv
module busdp_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] res_data
);
  logic [2:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= (busy_run == 3'd7) ? busy_run : busy_run + 3'd1;
    else           busy_run <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (!busy && !done));

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  assert_busy_span_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy, 1) && $past(busy, 2) && $past(busy, 3) && !busy));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_res_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(res_data));

  assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < 3'd3));
endmodule

bind busdp_seq busdp_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .done(done), .res_data(res_data)
);

// File: tb/busdp_seq_tb.sv
module busdp_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_func = '0;
  logic [3:0]  req_dst = '0, req_srca = '0, req_srcb = '0;
  logic        req_shl = 1'b0;
  logic [4:0]  req_shamt = '0;
  logic        busy, done;
  logic [31:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model [16];

  always #10 clk = ~clk;

  busdp_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_func(req_func),
    .req_dst(req_dst), .req_srca(req_srca), .req_srcb(req_srcb),
    .req_shl(req_shl), .req_shamt(req_shamt), .busy(busy), .done(done),
    .res_data(res_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_op(input logic [2:0] f, input logic [31:0] l,
                                            input logic [31:0] r, input logic sl,
                                            input logic [4:0] sa);
    logic [31:0] s;
    s = sl ? (r << sa) : (r >> sa);
    case (f)
      3'd0: return l + s;
      3'd1: return l - s;
      3'd2: return l & s;
      3'd3: return l | s;
      3'd4: return l ^ s;
      default: return s;
    endcase
  endfunction

  // issue one operation; optionally present a competing request while busy
  task automatic run_op(input logic [2:0] f, input logic [3:0] d, input logic [3:0] a,
                        input logic [3:0] b, input logic sl, input logic [4:0] sa,
                        input bit inject, input string tag);
    logic [31:0] exp;
    exp = expect_op(f, model[a], model[b], sl, sa);
    @(negedge clk);
    req_valid = 1'b1; req_func = f; req_dst = d; req_srca = a; req_srcb = b;
    req_shl = sl; req_shamt = sa;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after accept", {31'd0, busy}, 32'd1);
    if (inject) begin
      req_valid = 1'b1; req_func = 3'd5; req_dst = 4'd6; req_srca = 4'd0;
      req_srcb = 4'd0; req_shamt = 5'd0;
    end
    @(negedge clk);
    check("R2 busy mid-op", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check("R3 no early done", {31'd0, done}, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    check("R3 done pulse", {31'd0, done}, 32'd1);
    check("R3 idle at done", {31'd0, busy}, 32'd0);
    check(tag, res_data, exp);
    model[d] = exp;
    @(negedge clk);
    check("R3 done one cycle", {31'd0, done}, 32'd0);
    if (inject) check("R4 no second op", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) model[k] = 32'h9E3779B9 * (k + 1);
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    check("R1 res after reset", res_data, 32'd0);

    // R1 initial contents seen through pass with no shift
    run_op(3'd5, 4'd0, 4'd0, 4'd9, 1'b0, 5'd0, 0, "R1 reset value r9");
    run_op(3'd0, 4'd1, 4'd2, 4'd3, 1'b0, 5'd0, 0, "R5 add");
    run_op(3'd1, 4'd2, 4'd4, 4'd5, 1'b0, 5'd0, 0, "R5 sub");
    run_op(3'd1, 4'd7, 4'd0, 4'd15, 1'b1, 5'd31, 0, "R5 sub wrap with R7 shl 31");
    run_op(3'd2, 4'd8, 4'd8, 4'd11, 1'b0, 5'd4, 0, "R6 and with R7 shr 4");
    run_op(3'd3, 4'd9, 4'd10, 4'd12, 1'b1, 5'd8, 0, "R6 or with R7 shl 8");
    run_op(3'd4, 4'd10, 4'd13, 4'd14, 1'b0, 5'd31, 0, "R6 xor with R7 shr 31");
    run_op(3'd7, 4'd11, 4'd3, 4'd3, 1'b0, 5'd16, 0, "R6 pass code 7");
    run_op(3'd1, 4'd3, 4'd3, 4'd3, 1'b0, 5'd0, 0, "R8 dst equals both sources");
    run_op(3'd0, 4'd4, 4'd4, 4'd5, 1'b1, 5'd1, 0, "R8 dst equals left source");
    run_op(3'd0, 4'd5, 4'd1, 4'd5, 1'b0, 5'd0, 0, "R8 dst equals right source");
    run_op(3'd5, 4'd12, 4'd0, 4'd3, 1'b0, 5'd0, 0, "R9 earlier result readable");
    // R4: competing request aimed at r6 while busy
    run_op(3'd0, 4'd5, 4'd1, 4'd2, 1'b0, 5'd0, 1, "R4 main op unaffected");
    run_op(3'd5, 4'd13, 4'd0, 4'd6, 1'b0, 5'd0, 0, "R4 r6 untouched");

    for (int n = 0; n < 200; n++) begin
      logic [2:0] f;
      logic [3:0] d, a, b;
      logic       sl;
      logic [4:0] sa;
      f = 3'($urandom_range(0, 7));
      d = 4'($urandom_range(0, 15));
      a = 4'($urandom_range(0, 15));
      b = 4'($urandom_range(0, 15));
      sl = 1'($urandom_range(0, 1));
      sa = 5'($urandom_range(0, 31));
      run_op(f, d, a, b, sl, sa, (n % 17) == 3, "R9 random op");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule